// File: doc/BRIEF.md
# Stepwise Shifting ALU with Zero-Compare Flags

This block is the arithmetic core of a small multi-cycle processor. It keeps two operand registers, an accumulator and a second operand. The accumulator is loaded from one bus. The second operand is loaded either from another bus or from a short signed literal taken out of an instruction. A 3-bit function code selects a logic or arithmetic operation, and the result is written back into the accumulator together with a carry bit.

Shifts and rotates are done in steps. Each clock with the shift strobe raised moves the accumulator by exactly one bit position. An outside sequencer holds the strobe for as many cycles as the shift distance. Two flags compare the accumulator against zero: one for equality and one for signed greater-than. A conditional-jump unit uses these flags. An output-enabled copy of the accumulator feeds the register file write path.

The reset input is asynchronous and active low. Its release is synchronized inside the block, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `stepshift_alu`

## Requirements
- R1: While reset is active, and after it is released, the accumulator, the second operand and the carry all read zero until a strobe changes them. In that state `is_zero` is 1 and `is_greater` is 0.
- R2: `load_acc` captures `bus_acc` into the accumulator. `load_opb` captures `bus_opb` into the second operand. When no strobe is active, both registers and the carry keep their values.
- R3: `load_imm` captures `imm6` into the second operand after sign-extending it, so bit 5 is copied into bits 7:6 (for example 6'b111110 becomes 8'hFE). When `load_imm` and `load_opb` are both high, the literal wins.
- R4: When `op_go` is high, the function code `op_sel` updates the accumulator on that edge. The codes are: 000 AND, 001 OR, 100 pass (accumulator unchanged), 101 NOT of the accumulator, 110 XOR, 111 accumulator unchanged. For all of these codes the carry becomes 0, and the second operand does not matter for 100, 101 and 111.
- R5: Code 010 writes the low 8 bits of accumulator + operand and sets the carry to bit 8 of the sum (100 + 145 gives 245 with carry 0).
- R6: Code 011 writes accumulator + ~operand + 1, so the carry is 1 exactly when the accumulator is at least the operand, compared as unsigned values.
- R7: When `shift_go` is high, the shift code `shift_sel` moves the accumulator one bit per clock edge. The codes are: 01 left with 0 into bit 0, 10 right with 0 into bit 7, 11 rotate right with bit 0 into bit 7, and 00 no change. A shift never changes the carry.
- R8: The strobes acting on the accumulator have a fixed priority: `load_acc` first, then `op_go`, then `shift_go`. A strobe that loses is ignored. This includes the carry update of `op_go`.
- R9: `is_zero` is 1 exactly when the accumulator is 8'h00.
- R10: `is_greater` is 1 exactly when the accumulator, read as a two's-complement value, is strictly greater than zero. It is 0 for 8'h00 and for 8'h80 through 8'hFF.
- R11: `result` always shows the accumulator. `acc_drive` shows the accumulator when `drive_en` is 1 and shows 8'h00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_acc | input | 8 | Accumulator load data |
| bus_opb | input | 8 | Second-operand load data |
| imm6 | input | 6 | Signed literal for the second operand |
| load_acc | input | 1 | Load accumulator from bus_acc |
| load_opb | input | 1 | Load second operand from bus_opb |
| load_imm | input | 1 | Load second operand from sign-extended imm6 |
| op_go | input | 1 | Apply op_sel into accumulator and carry |
| op_sel | input | 3 | Function code |
| shift_go | input | 1 | Apply one shift step |
| shift_sel | input | 2 | Shift code |
| drive_en | input | 1 | Enable accumulator onto acc_drive |
| result | output | 8 | Accumulator value |
| acc_drive | output | 8 | Gated accumulator for write-back |
| carry_out | output | 1 | Carry captured with the last applied operation |
| is_zero | output | 1 | Accumulator equals zero |
| is_greater | output | 1 | Accumulator signed greater than zero |

## Verification
The hardest cases to reach are the ones where strobes arrive together. When `load_acc`, `op_go` and `shift_go` are raised in the same cycle, the losing strobes must leave no trace, and the carry is the only place where a wrongly applied operation would still be visible. The stimulus therefore first sets up a nonzero carry with an overflowing addition. It then raises all three strobes at once, and afterwards raises an operation together with a shift, so the bench can see whether the carry or the accumulator picked up the wrong update. Shift chains of several steps, and a rotate across bit 0, are run and checked one cycle at a time.

// File: rtl/stepshift_alu_pkg.sv
package stepshift_alu_pkg;
  typedef enum logic [2:0] {
    FN_AND  = 3'b000,
    FN_OR   = 3'b001,
    FN_ADD  = 3'b010,
    FN_SUB  = 3'b011,
    FN_PASS = 3'b100,
    FN_NOT  = 3'b101,
    FN_XOR  = 3'b110,
    FN_RSVD = 3'b111
  } fn_code_e;

  typedef enum logic [1:0] {
    SH_HOLD = 2'b00,
    SH_LEFT = 2'b01,
    SH_RGHT = 2'b10,
    SH_ROTR = 2'b11
  } sh_code_e;
endpackage

// File: rtl/stepshift_fn_unit.sv
module stepshift_fn_unit
  import stepshift_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opb_i,
  input  fn_code_e     fn_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic         is_sub;
  logic [W-1:0] opb_eff;
  logic [W:0]   sum;

  always_comb begin
    is_sub  = (fn_i == FN_SUB);
    opb_eff = is_sub ? ~opb_i : opb_i;
    sum     = {1'b0, acc_i} + {1'b0, opb_eff} + {{W{1'b0}}, is_sub};
  end

  always_comb begin
    res_o  = acc_i;
    cout_o = 1'b0;
    unique case (fn_i)
      FN_AND:  res_o = acc_i & opb_i;
      FN_OR:   res_o = acc_i | opb_i;
      FN_ADD,
      FN_SUB:  begin
        res_o  = sum[W-1:0];
        cout_o = sum[W];
      end
      FN_PASS: res_o = acc_i;
      FN_NOT:  res_o = ~acc_i;
      FN_XOR:  res_o = acc_i ^ opb_i;
      FN_RSVD: res_o = acc_i;
    endcase
  end
endmodule

// File: rtl/stepshift_step.sv
module stepshift_step
  import stepshift_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_i,
  input  sh_code_e     sh_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (sh_i)
      SH_HOLD: res_o = acc_i;
      SH_LEFT: res_o = {acc_i[W-2:0], 1'b0};
      SH_RGHT: res_o = {1'b0, acc_i[W-1:1]};
      SH_ROTR: res_o = {acc_i[0], acc_i[W-1:1]};
    endcase
  end
endmodule

// File: rtl/stepshift_flags.sv
module stepshift_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_i,
  output logic         zero_o,
  output logic         gt_o
);
  always_comb begin
    zero_o = ~|acc_i;
    gt_o   = ~acc_i[W-1] & ~zero_o;
  end
endmodule

// File: rtl/stepshift_alu.sv
module stepshift_alu
  import stepshift_alu_pkg::*;
#(
  parameter int W     = 8,
  parameter int IMM_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     bus_acc,
  input  logic [W-1:0]     bus_opb,
  input  logic [IMM_W-1:0] imm6,
  input  logic             load_acc,
  input  logic             load_opb,
  input  logic             load_imm,
  input  logic             op_go,
  input  logic [2:0]       op_sel,
  input  logic             shift_go,
  input  logic [1:0]       shift_sel,
  input  logic             drive_en,
  output logic [W-1:0]     result,
  output logic [W-1:0]     acc_drive,
  output logic             carry_out,
  output logic             is_zero,
  output logic             is_greater
);
  localparam int EXT_W = W - IMM_W;

  logic [1:0]   rst_pipe;
  logic         rst_sync_n;
  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] opb_q, opb_d;
  logic         cy_q, cy_d;
  logic [W-1:0] fn_res, sh_res, imm_ext;
  logic         fn_cout;
  logic         take_op, take_sh;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  stepshift_fn_unit #(.W(W)) u_fn (
    .acc_i (acc_q),
    .opb_i (opb_q),
    .fn_i  (fn_code_e'(op_sel)),
    .res_o (fn_res),
    .cout_o(fn_cout)
  );

  stepshift_step #(.W(W)) u_step (
    .acc_i(acc_q),
    .sh_i (sh_code_e'(shift_sel)),
    .res_o(sh_res)
  );

  stepshift_flags #(.W(W)) u_flags (
    .acc_i (acc_q),
    .zero_o(is_zero),
    .gt_o  (is_greater)
  );

  // Next state: load beats operation, operation beats shift
  always_comb begin
    imm_ext = {{EXT_W{imm6[IMM_W-1]}}, imm6};
    take_op = op_go & ~load_acc;
    take_sh = shift_go & ~op_go & ~load_acc;
    acc_d   = acc_q;
    cy_d    = cy_q;
    opb_d   = opb_q;
    if (load_acc) begin
      acc_d = bus_acc;
    end else if (take_op) begin
      acc_d = fn_res;
      cy_d  = fn_cout;
    end else if (take_sh) begin
      acc_d = sh_res;
    end
    if (load_imm)      opb_d = imm_ext;
    else if (load_opb) opb_d = bus_opb;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q <= '0;
      opb_q <= '0;
      cy_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      opb_q <= opb_d;
      cy_q  <= cy_d;
    end
  end

  assign result    = acc_q;
  assign carry_out = cy_q;
  assign acc_drive = drive_en ? acc_q : '0;

  // Checks
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_acc && !op_go && !shift_go && !load_opb && !load_imm)
      |=> ($stable(result) && $stable(carry_out) && $stable(opb_q)));

  assert_load_acc_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_acc |=> (result == $past(bus_acc)));

  assert_shift_keeps_carry_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shift_go && !op_go && !load_acc) |=> $stable(carry_out));

  assert_rotate_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shift_go && !op_go && !load_acc && shift_sel == 2'b11)
      |=> (result == {$past(result[0]), $past(result[W-1:1])}));

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(is_zero && is_greater));

  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_zero |-> (result == '0));

  assert_drive_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    drive_en |-> (acc_drive == result));
endmodule

// File: tb/stepshift_alu_test.sv
module stepshift_alu_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_acc, bus_opb;
  logic [5:0] imm6;
  logic       load_acc, load_opb, load_imm, op_go, shift_go, drive_en;
  logic [2:0] op_sel;
  logic [1:0] shift_sel;
  logic [7:0] result, acc_drive;
  logic       carry_out, is_zero, is_greater;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] m_acc = 8'h00;
  logic [7:0] m_opb = 8'h00;
  logic       m_cy  = 1'b0;

  typedef struct {
    logic [7:0] acc;
    logic       cy;
    logic       de;
    string      req;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  stepshift_alu uut (
    .clk(clk), .rst_n(rst_n), .bus_acc(bus_acc), .bus_opb(bus_opb), .imm6(imm6),
    .load_acc(load_acc), .load_opb(load_opb), .load_imm(load_imm),
    .op_go(op_go), .op_sel(op_sel), .shift_go(shift_go), .shift_sel(shift_sel),
    .drive_en(drive_en), .result(result), .acc_drive(acc_drive),
    .carry_out(carry_out), .is_zero(is_zero), .is_greater(is_greater)
  );

  task automatic check_state(input logic [7:0] acc, input logic cy, input logic de,
                             input string req);
    logic [7:0] drv;
    logic       z, g;
    drv = de ? acc : 8'h00;
    z = (acc == 8'h00);
    g = !acc[7] && !z;
    checks++;
    if (result !== acc || carry_out !== cy || is_zero !== z || is_greater !== g ||
        acc_drive !== drv) begin
      fails++;
      $display("FAIL %s: got res=%h cy=%b z=%b g=%b drv=%h, expected res=%h cy=%b z=%b g=%b drv=%h",
               req, result, carry_out, is_zero, is_greater, acc_drive, acc, cy, z, g, drv);
    end
  endtask

  // Monitor: compare the oldest expected item just after each edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check_state(e.acc, e.cy, e.de, e.req);
    end
  end

  // Driver: one cycle of stimulus, model computed from the requirements
  task automatic step(input logic la, input logic lb, input logic li, input logic og,
                      input logic [2:0] op, input logic sg, input logic [1:0] sh,
                      input logic de, input logic [7:0] ba, input logic [7:0] bb,
                      input logic [5:0] im, input string req);
    logic [8:0] s;
    exp_t e;
    @(negedge clk);
    load_acc = la; load_opb = lb; load_imm = li; op_go = og; op_sel = op;
    shift_go = sg; shift_sel = sh; drive_en = de; bus_acc = ba; bus_opb = bb; imm6 = im;
    if (la) m_acc = ba;
    else if (og) begin
      m_cy = 1'b0;
      case (op)
        3'b000: m_acc = m_acc & m_opb;
        3'b001: m_acc = m_acc | m_opb;
        3'b010: begin s = m_acc + m_opb; m_acc = s[7:0]; m_cy = s[8]; end
        3'b011: begin s = {1'b0, m_acc} + {1'b0, ~m_opb} + 9'd1; m_acc = s[7:0]; m_cy = s[8]; end
        3'b101: m_acc = ~m_acc;
        3'b110: m_acc = m_acc ^ m_opb;
        default: ;
      endcase
    end else if (sg) begin
      case (sh)
        2'b01: m_acc = {m_acc[6:0], 1'b0};
        2'b10: m_acc = {1'b0, m_acc[7:1]};
        2'b11: m_acc = {m_acc[0], m_acc[7:1]};
        default: ;
      endcase
    end
    if (li) m_opb = {{2{im[5]}}, im};
    else if (lb) m_opb = bb;
    e.acc = m_acc; e.cy = m_cy; e.de = de; e.req = req;
    sb.push_back(e);
  endtask

  task automatic lda(input logic [7:0] v, input string req);
    step(1, 0, 0, 0, 3'b000, 0, 2'b00, 0, v, 8'h00, 6'h00, req);
  endtask
  task automatic ldb(input logic [7:0] v, input string req);
    step(0, 1, 0, 0, 3'b000, 0, 2'b00, 0, 8'h00, v, 6'h00, req);
  endtask
  task automatic fn(input logic [2:0] op, input string req);
    step(0, 0, 0, 1, op, 0, 2'b00, 0, 8'h00, 8'h00, 6'h00, req);
  endtask
  task automatic sft(input logic [1:0] sh, input string req);
    step(0, 0, 0, 0, 3'b000, 1, sh, 0, 8'h00, 8'h00, 6'h00, req);
  endtask
  task automatic idle(input logic de, input string req);
    step(0, 0, 0, 0, 3'b000, 0, 2'b00, de, 8'h5A, 8'hA5, 6'h15, req);
  endtask

  initial begin
    rst_n = 1'b0;
    load_acc = 0; load_opb = 0; load_imm = 0; op_go = 0; shift_go = 0; drive_en = 0;
    op_sel = 0; shift_sel = 0; bus_acc = 0; bus_opb = 0; imm6 = 0;
    repeat (3) @(negedge clk);
    check_state(8'h00, 1'b0, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_state(8'h00, 1'b0, 1'b0, "R1 after release");

    // R5 adder
    lda(8'd100, "R2 load acc");
    ldb(8'd145, "R2 load opb");
    fn(3'b010, "R5 100+145");
    lda(8'd155, "R2 load acc");
    ldb(8'd110, "R2 load opb");
    fn(3'b010, "R5 155+110 carry");
    idle(1'b0, "R2 hold carry and acc");
    // R6 subtract
    lda(8'd155, "R2 load acc");
    fn(3'b011, "R6 155-110");
    lda(8'd10, "R2 load acc");
    ldb(8'd20, "R2 load opb");
    fn(3'b011, "R6 10-20 borrow");
    lda(8'd20, "R2 load acc");
    fn(3'b011, "R6 equal operands");
    // R3 literal operand
    lda(8'd7, "R2 load acc");
    step(0, 0, 1, 0, 3'b000, 0, 2'b00, 0, 8'h00, 8'h00, 6'b111110, "R3 load -2");
    fn(3'b010, "R3 7 + (-2)");
    step(0, 1, 1, 0, 3'b000, 0, 2'b00, 0, 8'h00, 8'h33, 6'b000101, "R3 literal wins");
    fn(3'b010, "R3 5 + 5");
    // R4 logic on 9B / 6E
    lda(8'h9B, "R2 load acc");
    ldb(8'h6E, "R2 load opb");
    fn(3'b000, "R4 AND");
    lda(8'h9B, "R2"); fn(3'b001, "R4 OR");
    lda(8'h9B, "R2"); fn(3'b110, "R4 XOR");
    lda(8'h9B, "R2"); fn(3'b101, "R4 NOT");
    fn(3'b100, "R4 pass");
    fn(3'b111, "R4 code 111");
    // carry cleared by logic op
    lda(8'hFF, "R2"); ldb(8'h01, "R2"); fn(3'b010, "R5 FF+1 wrap");
    fn(3'b001, "R4 OR clears carry");
    // R7 shift chains
    lda(8'h81, "R2");
    sft(2'b01, "R7 left"); sft(2'b01, "R7 left"); sft(2'b00, "R7 hold code");
    lda(8'h81, "R2");
    sft(2'b10, "R7 right"); sft(2'b10, "R7 right");
    lda(8'h81, "R2");
    for (int i = 0; i < 9; i++) sft(2'b11, "R7 rotate");
    // R8 priority, with carry set first
    lda(8'hF0, "R2"); ldb(8'h20, "R2"); fn(3'b010, "R5 carry set");
    step(1, 0, 0, 1, 3'b101, 1, 2'b01, 0, 8'h3C, 8'h00, 6'h00, "R8 load beats op and shift");
    step(0, 0, 0, 1, 3'b000, 1, 2'b01, 0, 8'h00, 8'h00, 6'h00, "R8 op beats shift");
    step(0, 0, 0, 0, 3'b000, 1, 2'b10, 0, 8'h00, 8'h00, 6'h00, "R8 shift alone");
    // R9 / R10 flags
    lda(8'h80, "R10 most negative");
    lda(8'h7F, "R10 most positive");
    lda(8'h01, "R10 one");
    lda(8'hFF, "R10 minus one");
    lda(8'h00, "R9 zero");
    // R11 drive
    lda(8'hC3, "R2");
    idle(1'b1, "R11 drive on");
    idle(1'b0, "R11 drive off");
    idle(1'b0, "R11 settle");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule